// File: doc/BRIEF.md
# PWM Clock Prescaler and Scaler

This block turns the system clock into the clock-enable ticks that a bank of eight PWM channel counters advance on. Two independent chains, A and B, each start with a power-of-two prescaler whose 3-bit code selects a division of 1, 2, 4 and so on up to 128. Each chain then feeds a scaled divider that divides the prescaled tick again by an even ratio 2×N, where N is an 8-bit register value and N = 0 stands for 256. The two stages together can divide by as much as 65,536.

Every output is a one-cycle enable, synchronous to the system clock; nothing is gated. Each of the eight channel ticks is the raw or the scaled tick of a fixed chain: channels 0, 1, 4 and 5 belong to chain A, channels 2, 3, 6 and 7 to chain B, and a per-channel select bit picks raw (0) or scaled (1). A small register interface with a write strobe and a combinational read port holds the select, prescale and scale settings. These are plain control pins; there is no data stream and no back-pressure.

Top module: `pwmclk_top`

## Requirements
- R1: After reset every register reads 0, so both raw ticks fire on every cycle, both scaled ticks fire once every 512 cycles and every channel follows its raw tick.
- R2: The prescale register (address 1) holds the chain A code in bits 2:0 and the chain B code in bits 6:4; code c makes the raw tick fire once every 2^c cycles, on every cycle when c = 0.
- R3: Scale registers at address 2 (chain A) and address 3 (chain B) hold N; the scaled tick fires on every 2×N-th raw tick of its chain, in the same cycle as that raw tick.
- R4: A scale value N = 0 behaves as N = 256, giving one scaled tick every 512 raw ticks.
- R5: The select register (address 0) bit i routes channel i: 0 gives the raw tick and 1 the scaled tick of its chain; channels whose index has bit 1 clear use chain A, the others chain B.
- R6: Prescale code 7 with N = 0 yields one scaled tick every 65,536 cycles.
- R7: A write to the prescale register restarts both prescalers and both scaled dividers from zero: counting the cycle after the write edge as cycle 0, the raw tick of division P first fires in cycle P-1.
- R8: A write to a scale register restarts only that chain's scaled divider; the other chain's scaled tick and both raw ticks keep their phase.
- R9: The read port returns the addressed register in the same cycle; prescale bits 3 and 7 are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Addressed register contents |
| tick_a | output | 1 | Raw chain A enable |
| tick_b | output | 1 | Raw chain B enable |
| tick_sa | output | 1 | Scaled chain A enable |
| tick_sb | output | 1 | Scaled chain B enable |
| chan_tick | output | 8 | Per-channel selected enable |

## Verification
All ticks are decoded combinationally from counter state, so a tick belongs to the cycle in which the counters hold it, and a register write takes effect at the edge that ends the write cycle; the read port answers in the cycle of the address. The bench counts cycles from the edge that completes the last write, queues one expected tick vector per following cycle from the division arithmetic, and compares one vector per falling edge. The scale-restart case keeps a separate cycle offset for the undisturbed chain, so its phase across the write is checked too.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
  typedef enum logic [1:0] {
    REG_SEL = 2'd0,
    REG_PRE = 2'd1,
    REG_SCA = 2'd2,
    REG_SCB = 2'd3
  } reg_addr_e;

  localparam int CHAIN_A = 0;
  localparam int CHAIN_B = 1;
  localparam int NUM_CHAINS = 2;
endpackage

// File: rtl/pwmclk_prediv.sv
module pwmclk_prediv #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'((32'd1 << code) - 32'd1);
    tick = (cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (tick && lim != '0 && !restart) |=> !tick) else $error("prescaler ticked twice in a row"); // R2
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (cnt == '0)) else $error("prescaler not restarted"); // R7
  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= lim) else $error("prescaler count past limit"); // R7
endmodule

// File: rtl/pwmclk_scaler.sv
module pwmclk_scaler #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               in_tick,
  input  logic [SCALE_W-1:0] n,
  output logic               tick
);
  localparam int CNT_W = SCALE_W + 1;

  logic [CNT_W-1:0]   cnt;
  logic [SCALE_W-1:0] n_m1;
  logic [CNT_W-1:0]   lim;

  always_comb begin
    n_m1 = n - {{(SCALE_W-1){1'b0}}, 1'b1};
    lim  = {n_m1, 1'b1};
    tick = in_tick && (cnt == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (in_tick) cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
  end

  AST_SC_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (tick && !restart) |=> !tick) else $error("scaled tick twice in a row"); // R3
  AST_SC_RESTART: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (cnt == '0)) else $error("scaler not restarted"); // R8
  AST_SC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= lim) else $error("scaler count past limit"); // R4
endmodule

// File: rtl/pwmclk_regs.sv
module pwmclk_regs
  import pwmclk_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int SCALE_W = 8,
  parameter int NCH     = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NCH-1:0]     sel,
  output logic [CODE_W-1:0]  code_a,
  output logic [CODE_W-1:0]  code_b,
  output logic [SCALE_W-1:0] n_a,
  output logic [SCALE_W-1:0] n_b,
  output logic               pre_wr,
  output logic               sca_wr,
  output logic               scb_wr
);
  localparam int B_LSB = DATA_W / 2;

  logic sel_wr;

  always_comb begin
    sel_wr = wr_en && (wr_addr == REG_SEL);
    pre_wr = wr_en && (wr_addr == REG_PRE);
    sca_wr = wr_en && (wr_addr == REG_SCA);
    scb_wr = wr_en && (wr_addr == REG_SCB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel    <= '0;
      code_a <= '0;
      code_b <= '0;
      n_a    <= '0;
      n_b    <= '0;
    end else begin
      if (sel_wr) sel <= wr_data[NCH-1:0];
      if (pre_wr) begin
        code_a <= wr_data[CODE_W-1:0];
        code_b <= wr_data[B_LSB +: CODE_W];
      end
      if (sca_wr) n_a <= wr_data[SCALE_W-1:0];
      if (scb_wr) n_b <= wr_data[SCALE_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_SEL: rd_data[NCH-1:0] = sel;
      REG_PRE: begin
        rd_data[CODE_W-1:0]       = code_a;
        rd_data[B_LSB +: CODE_W]  = code_b;
      end
      REG_SCA: rd_data[SCALE_W-1:0] = n_a;
      default: rd_data[SCALE_W-1:0] = n_b;
    endcase
  end

  AST_SCALE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) sca_wr |=> (n_a == $past(wr_data[SCALE_W-1:0]))) else $error("scale A not loaded"); // R3
endmodule

// File: rtl/pwmclk_top.sv
module pwmclk_top
  import pwmclk_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int SCALE_W = 8,
  parameter int NCH     = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_a,
  output logic              tick_b,
  output logic              tick_sa,
  output logic              tick_sb,
  output logic [NCH-1:0]    chan_tick
);
  logic [NCH-1:0]                         sel;
  logic [NUM_CHAINS-1:0][CODE_W-1:0]      code_v;
  logic [NUM_CHAINS-1:0][SCALE_W-1:0]     n_v;
  logic                                   pre_wr, sca_wr, scb_wr;
  logic [NUM_CHAINS-1:0]                  sc_restart;
  logic [NUM_CHAINS-1:0]                  raw_tick, scl_tick;

  pwmclk_regs #(
    .CODE_W(CODE_W), .SCALE_W(SCALE_W), .NCH(NCH), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sel(sel),
    .code_a(code_v[CHAIN_A]), .code_b(code_v[CHAIN_B]),
    .n_a(n_v[CHAIN_A]), .n_b(n_v[CHAIN_B]),
    .pre_wr(pre_wr), .sca_wr(sca_wr), .scb_wr(scb_wr)
  );

  assign sc_restart[CHAIN_A] = pre_wr | sca_wr;
  assign sc_restart[CHAIN_B] = pre_wr | scb_wr;

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    pwmclk_prediv #(.CODE_W(CODE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(pre_wr),
      .code(code_v[g]), .tick(raw_tick[g])
    );
    pwmclk_scaler #(.SCALE_W(SCALE_W)) u_scl (
      .clk(clk), .rst_n(rst_n), .restart(sc_restart[g]),
      .in_tick(raw_tick[g]), .n(n_v[g]), .tick(scl_tick[g])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam int GRP = (i / 2) % 2;
    assign chan_tick[i] = sel[i] ? scl_tick[GRP] : raw_tick[GRP];
  end

  assign tick_a  = raw_tick[CHAIN_A];
  assign tick_b  = raw_tick[CHAIN_B];
  assign tick_sa = scl_tick[CHAIN_A];
  assign tick_sb = scl_tick[CHAIN_B];
endmodule

// File: tb/tb_pwmclk_top.sv
module tb_pwmclk_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_a, tick_b, tick_sa, tick_sb;
  logic [7:0] chan_tick;

  pwmclk_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_a(tick_a), .tick_b(tick_b),
    .tick_sa(tick_sa), .tick_sb(tick_sb), .chan_tick(chan_tick)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] cur_sel = '0;
  int cur_ca = 0, cur_cb = 0, cur_na = 0, cur_nb = 0;

  function automatic logic [11:0] expect_vec(int ka, int kb);
    int pa, pb, ea, eb;
    logic a, b, sa, sb;
    logic [7:0] ch;
    pa = 1 << cur_ca;
    pb = 1 << cur_cb;
    ea = (cur_na == 0) ? 256 : cur_na;
    eb = (cur_nb == 0) ? 256 : cur_nb;
    a  = ((ka + 1) % pa) == 0;
    b  = ((kb + 1) % pb) == 0;
    sa = ((ka + 1) % (pa * 2 * ea)) == 0;
    sb = ((kb + 1) % (pb * 2 * eb)) == 0;
    for (int i = 0; i < 8; i++) begin
      if (((i / 2) % 2) == 1) ch[i] = cur_sel[i] ? sb : b;
      else                    ch[i] = cur_sel[i] ? sa : a;
    end
    return {a, b, sa, sb, ch};
  endfunction

  // driver: queue expected vectors, cycle 0 is the one after the last write edge
  task automatic run(int count, int off_a, int off_b, string tag);
    for (int k = 0; k < count; k++) begin
      exp_q.push_back(expect_vec(k + off_a, k + off_b));
      tag_q.push_back(tag);
    end
    wait (exp_q.size() == 0);
  endtask

  task automatic write_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic chk_read(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    n_chk++;
    if (rd_data !== e) begin
      n_bad++;
      $display("FAIL %s: read addr %0d actual=%h expected=%h", tag, a, rd_data, e);
    end
  endtask

  task automatic config_all(logic [7:0] s, int ca, int cb, int na, int nb);
    write_reg(2'd0, s);
    write_reg(2'd2, 8'(na));
    write_reg(2'd3, 8'(nb));
    write_reg(2'd1, {1'b0, 3'(cb), 1'b0, 3'(ca)});
    cur_sel = s; cur_ca = ca; cur_cb = cb; cur_na = na; cur_nb = nb;
  endtask

  // monitor: one comparison per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({tick_a, tick_b, tick_sa, tick_sb, chan_tick} !== e) begin
        n_bad++;
        $display("FAIL %s: ticks actual=%h expected=%h", t,
                 {tick_a, tick_b, tick_sa, tick_sb, chan_tick}, e);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 and R4: default divide 1 raw, 512 scaled
    run(1030, 0, 0, "R1_R4");
    chk_read(2'd0, 8'h00, "R1");
    chk_read(2'd1, 8'h00, "R1");
    chk_read(2'd2, 8'h00, "R1");
    chk_read(2'd3, 8'h00, "R1");

    // R2 R3 R5 R7: mixed codes and selects
    config_all(8'h5A, 1, 2, 3, 1);
    run(80, 0, 0, "R2_R3_R5_R7");
    chk_read(2'd0, 8'h5A, "R5");
    chk_read(2'd1, 8'h21, "R2");
    chk_read(2'd2, 8'h03, "R3");
    chk_read(2'd3, 8'h01, "R3");

    config_all(8'hCC, 0, 3, 2, 5);
    run(250, 0, 0, "R2_R3_R5");

    config_all(8'h33, 2, 1, 0, 2);
    run(2100, 0, 0, "R4_R5");

    // R9: unused prescale bits
    write_reg(2'd1, 8'hFF);
    cur_ca = 7; cur_cb = 7;
    chk_read(2'd1, 8'h77, "R9");

    // R8: scale A rewrite mid-run, chain B keeps phase
    config_all(8'hFF, 0, 0, 4, 3);
    run(10, 0, 0, "R7");
    write_reg(2'd2, 8'd2);
    cur_na = 2;
    run(40, 0, 11, "R8");

    // R6: full-range division
    config_all(8'h01, 7, 0, 0, 1);
    run(65540, 0, 0, "R6");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule